// File: doc/BRIEF.md
# Inter-processor receive queue controller

This block keeps the put and get indices of a circular receive queue that two processors share. The queue holds `lastIdx + 1` slots, where `lastIdx` is the index of the final slot. Each accepted push advances the put index and each accepted pop advances the get index, and both wrap back to zero after `lastIdx`. The message memory sits outside the block and is addressed with the two indices.

Each processor has a plain register port onto one 32-bit control word. The local side loads the last-slot index and can set a reset bit. The remote side can set only a reset-request bit. Neither bit can be cleared by software. The queue reinitializes only once both bits are set: at the next clock edge the two indices return to zero and both bits clear together. A push or pop that arrives in that cycle is discarded.

A push into a full queue or a pop from an empty queue is refused, and a one-cycle error pulse follows.

Top module: `ipc_rxq_ctrl`

## Requirements
- R1: After reset, putIdx and getIdx are 0, both handshake bits are 0, the last-slot index equals parameter DEF_LAST (7), qEmpty is 1 and qFull and qErr are 0.
- R2: Both read ports return the same word: bit 31 is the local reset bit, bit 30 is the remote request bit, bits 29:16 read 0, and bits 15:0 are the last-slot index.
- R3: A local write with bit 31 = 1 sets the reset bit, and a local write with bit 31 = 0 leaves it unchanged. Every local write loads bits 15:0 into the last-slot index. Bit 30 of a local write is ignored.
- R4: A remote write with bit 30 = 1 sets the request bit. All other bits of a remote write are ignored, so the reset bit and the last-slot index do not change.
- R5: While only one of the two handshake bits is set, the indices keep their values and pushes and pops work normally.
- R6: At the first clock edge where both handshake bits are registered as set, putIdx and getIdx become 0 and both bits become 0.
- R7: An accepted push increments putIdx and an accepted pop increments getIdx. After the index equal to the last-slot index, each wraps to 0.
- R8: qEmpty is 1 exactly when putIdx equals getIdx. qFull is 1 exactly when putIdx advanced by one (with wrap) equals getIdx.
- R9: A push while qFull, or a pop while qEmpty, leaves the indices unchanged and drives qErr high for exactly the following cycle.
- R10: A push or pop presented at the edge where the reinitialization takes effect is discarded and raises no error, so both indices read 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| locWrEn | input | 1 | Local-side write strobe for the control word |
| locWrData | input | 32 | Local-side write data |
| locRdData | output | 32 | Local-side view of the control word |
| remWrEn | input | 1 | Remote-side write strobe for the control word |
| remWrData | input | 32 | Remote-side write data |
| remRdData | output | 32 | Remote-side view of the control word |
| pushStb | input | 1 | Request to advance the put index |
| popStb | input | 1 | Request to advance the get index |
| putIdx | output | IDX_W | Current put index |
| getIdx | output | IDX_W | Current get index |
| qEmpty | output | 1 | Queue empty |
| qFull | output | 1 | Queue full |
| qErr | output | 1 | One-cycle pulse after a refused push or pop |

## Verification
Two functions can fall in the same cycle: the handshake reinitialization and a pointer update from a push or pop. The bench sets the local bit and then the remote bit so that both are registered, and it presents a push and a pop in exactly that cycle. It passes only if both indices read zero, both bits are clear and no error pulse appears. A second case checks that with only one bit set, pushes and pops in the same cycles still move the indices.

// File: rtl/ipq_pkg.sv
package ipq_pkg;
  localparam int CTRL_W  = 32;
  localparam int RST_BIT = 31;
  localparam int REQ_BIT = 30;
  localparam int SIZE_W  = 16;

  typedef struct packed {
    logic doInit;
    logic doPush;
    logic doPop;
    logic ldSize;
  } ipq_strb_t;
endpackage

// File: rtl/ipq_ctrl.sv
module ipq_ctrl
  import ipq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              locWrEn,
  input  logic [CTRL_W-1:0] locWrData,
  input  logic              remWrEn,
  input  logic [CTRL_W-1:0] remWrData,
  input  logic              pushStb,
  input  logic              popStb,
  input  logic              qFull,
  input  logic              qEmpty,
  output ipq_strb_t         strb,
  output logic              resetBit,
  output logic              reqBit,
  output logic              qErr
);
  logic initNow;
  logic errNow;

  assign initNow = resetBit & reqBit;

  always_comb begin
    strb.doInit = initNow;
    strb.doPush = pushStb & ~qFull & ~initNow;
    strb.doPop  = popStb & ~qEmpty & ~initNow;
    strb.ldSize = locWrEn;
  end

  assign errNow = ~initNow & ((pushStb & qFull) | (popStb & qEmpty));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetBit <= 1'b0;
      reqBit   <= 1'b0;
      qErr     <= 1'b0;
    end else begin
      qErr <= errNow;
      if (initNow) begin
        resetBit <= 1'b0;
        reqBit   <= 1'b0;
      end else begin
        if (locWrEn && locWrData[RST_BIT]) resetBit <= 1'b1;
        if (remWrEn && remWrData[REQ_BIT]) reqBit   <= 1'b1;
      end
    end
  end

  // R3
  bit_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetBit) |-> $past(reqBit));

  // R6
  handshake_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resetBit && reqBit) |=> (!resetBit && !reqBit));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doPush |-> !qFull);

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doPop |-> !qEmpty);

  // R10
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resetBit && reqBit) |=> !qErr);
endmodule

// File: rtl/ipq_datapath.sv
module ipq_datapath
  import ipq_pkg::*;
#(
  parameter int IDX_W    = 16,
  parameter int DEF_LAST = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ipq_strb_t         strb,
  input  logic [CTRL_W-1:0] sizeData,
  output logic [IDX_W-1:0]  putIdx,
  output logic [IDX_W-1:0]  getIdx,
  output logic [IDX_W-1:0]  lastIdx,
  output logic              qEmpty,
  output logic              qFull
);
  logic [IDX_W-1:0] putNext;
  logic [IDX_W-1:0] getNext;

  assign putNext = (putIdx == lastIdx) ? '0 : putIdx + 1'b1;
  assign getNext = (getIdx == lastIdx) ? '0 : getIdx + 1'b1;
  assign qEmpty  = (putIdx == getIdx);
  assign qFull   = (putNext == getIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      putIdx  <= '0;
      getIdx  <= '0;
      lastIdx <= IDX_W'(DEF_LAST);
    end else begin
      if (strb.ldSize) lastIdx <= sizeData[IDX_W-1:0];
      if (strb.doInit) begin
        putIdx <= '0;
        getIdx <= '0;
      end else begin
        if (strb.doPush) putIdx <= putNext;
        if (strb.doPop)  getIdx <= getNext;
      end
    end
  end

  // R6
  init_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doInit |=> (putIdx == '0 && getIdx == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.doInit && !strb.doPush && !strb.doPop) |=> ($stable(putIdx) && $stable(getIdx)));
endmodule

// File: rtl/ipc_rxq_ctrl.sv
module ipc_rxq_ctrl
  import ipq_pkg::*;
#(
  parameter int IDX_W    = 16,
  parameter int DEF_LAST = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              locWrEn,
  input  logic [31:0]       locWrData,
  output logic [31:0]       locRdData,
  input  logic              remWrEn,
  input  logic [31:0]       remWrData,
  output logic [31:0]       remRdData,
  input  logic              pushStb,
  input  logic              popStb,
  output logic [IDX_W-1:0]  putIdx,
  output logic [IDX_W-1:0]  getIdx,
  output logic              qEmpty,
  output logic              qFull,
  output logic              qErr
);
  ipq_strb_t        strb;
  logic             resetBit;
  logic             reqBit;
  logic [IDX_W-1:0] lastIdx;
  logic [31:0]      ctrlWord;

  ipq_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .locWrEn(locWrEn), .locWrData(locWrData),
    .remWrEn(remWrEn), .remWrData(remWrData),
    .pushStb(pushStb), .popStb(popStb),
    .qFull(qFull), .qEmpty(qEmpty),
    .strb(strb), .resetBit(resetBit), .reqBit(reqBit), .qErr(qErr)
  );

  ipq_datapath #(.IDX_W(IDX_W), .DEF_LAST(DEF_LAST)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .sizeData(locWrData),
    .putIdx(putIdx), .getIdx(getIdx), .lastIdx(lastIdx),
    .qEmpty(qEmpty), .qFull(qFull)
  );

  assign ctrlWord  = {resetBit, reqBit, 14'b0, SIZE_W'(lastIdx)};
  assign locRdData = ctrlWord;
  assign remRdData = ctrlWord;
endmodule

// File: tb/ipc_rxq_ctrl_test.sv
module ipc_rxq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        locWrEn = 1'b0, remWrEn = 1'b0, pushStb = 1'b0, popStb = 1'b0;
  logic [31:0] locWrData = '0, remWrData = '0;
  logic [31:0] locRdData, remRdData;
  logic [15:0] putIdx, getIdx;
  logic        qEmpty, qFull, qErr;
  int          errCnt = 0, chkCnt = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_rxq_ctrl uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive strobes from one negedge to the next, then settle
  task automatic step(input logic lw, input logic [31:0] ld, input logic rw,
                      input logic [31:0] rd, input logic pu, input logic po);
    locWrEn = lw; locWrData = ld; remWrEn = rw; remWrData = rd;
    pushStb = pu; popStb = po;
    @(negedge clk);
    locWrEn = 0; remWrEn = 0; pushStb = 0; popStb = 0;
  endtask

  task automatic idle(); step(0, '0, 0, '0, 0, 0); endtask
  task automatic push(); step(0, '0, 0, '0, 1, 0); endtask
  task automatic pop();  step(0, '0, 0, '0, 0, 1); endtask

  task automatic testReset();
    chk("R1 put", 32'(putIdx), 0);
    chk("R1 get", 32'(getIdx), 0);
    chk("R1 word", locRdData, 32'h0000_0007);
    chk("R1 flags", {qEmpty, qFull, qErr}, 3'b100);
    chk("R2 same view", remRdData, locRdData);
  endtask

  task automatic testWrites();
    step(1, 32'h7FFF_0003, 0, '0, 0, 0);         // bit30 ignored, bits 29:16 dropped
    chk("R3 size load, bit30 ignored", locRdData, 32'h0000_0003);
    chk("R2 reserved zero", remRdData & 32'h3FFF_0000, 0);
    step(0, '0, 1, 32'hBFFF_FFFF, 0, 0);          // remote without bit30
    chk("R4 remote others ignored", locRdData, 32'h0000_0003);
  endtask

  task automatic testWrap();
    push(); push(); push();
    chk("R7 put after 3", 32'(putIdx), 3);
    chk("R8 full", {qEmpty, qFull}, 2'b01);
    push();
    chk("R9 push full held", 32'(putIdx), 3);
    chk("R9 err pulse", 32'(qErr), 1);
    idle();
    chk("R9 err one cycle", 32'(qErr), 0);
    pop(); pop(); pop();
    chk("R8 empty", {qEmpty, qFull, 30'(getIdx)}, {2'b10, 30'd3});
    pop();
    chk("R9 pop empty err", {qErr, 31'(getIdx)}, {1'b1, 31'd3});
    push();
    chk("R7 put wraps", 32'(putIdx), 0);
    pop();
    chk("R7 get wraps", 32'(getIdx), 0);
  endtask

  task automatic testOneSided();
    push(); push();
    step(1, 32'h8000_0003, 0, '0, 0, 0);
    chk("R3 reset bit set", locRdData, 32'h8000_0003);
    step(1, 32'h0000_0003, 0, '0, 1, 0);         // write 0, push in same cycle
    chk("R3 write0 keeps bit", remRdData, 32'h8000_0003);
    chk("R5 push with one bit", 32'(putIdx), 3);
    pop();
    chk("R5 pop with one bit", 32'(getIdx), 1);
  endtask

  task automatic testHandshake();
    step(0, '0, 1, 32'h4000_0000, 0, 0);
    chk("R4 request set", remRdData, 32'hC000_0003);
    chk("R6 not yet cleared", 32'(putIdx), 3);
    step(0, '0, 0, '0, 1, 1);                      // collision with init edge
    chk("R6/R10 put zero", 32'(putIdx), 0);
    chk("R6/R10 get zero", 32'(getIdx), 0);
    chk("R6 bits cleared", locRdData, 32'h0000_0003);
    chk("R10 no error", 32'(qErr), 0);
  endtask

  task automatic testRemoteOnly();
    push();
    step(0, '0, 1, 32'h4000_0000, 0, 0);
    idle(); idle();
    chk("R5 request alone holds", {locRdData, 16'(putIdx)}, {32'h4000_0003, 16'd1});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWrites();
    testWrap();
    testOneSided();
    testHandshake();
    testRemoteOnly();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      chkCnt++; errCnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end
endmodule